// File: doc/BRIEF.md
# Credit-Based Completion Interrupt Moderator

One instance of this block sits next to each descriptor completion ring and decides when that ring's interrupt vector gets an interrupt request. It takes a one-cycle pulse each time the device finishes a descriptor. It also takes a credit-return write, which carries the number of completed descriptors that software has finished handling. The block keeps a count of credits still outstanding at the driver and an internal auto-mask. When it requests an interrupt, it drives a one-cycle request tagged with the ring's vector number. Message delivery, the per-vector mask bits of the message table and the pending-bit table belong to the consumer of the request. The auto-mask kept here is separate from those per-vector mask bits.

The control is a two-state machine. In state OPEN the source is unmasked and no credits are outstanding. In state HELD the source is auto-masked and software owes work. The machine has three transitions:

- **arm-fire** (OPEN to HELD): taken when the count becomes non-zero. It raises one request.
- **partial-return refire** (HELD to HELD): taken when a credit return leaves credits outstanding. It raises a fresh request.
- **drain-unmask** (HELD to OPEN): taken when a credit return brings the count to zero. It raises no request.

Completions that arrive while the machine is HELD only add to the count. The vector number is a parameter. The usual assignment is:

| Vector | Use |
|---|---|
| 0 | Command ring |
| 1 | Event ring |
| 2 | Test operations |
| 4 and above | Transmit and receive rings |

Top module: `irq_credit_moderator`

## Requirements
- R1: A completion pulse in a cycle with no credit return raises the credit count by exactly one, visible on `credits` after that clock edge.
- R2: A credit-return write of amount N, where N does not exceed the count, lowers the count by N.
- R3: In state OPEN with zero credits, a completion raises `irq_req` for exactly one cycle after the edge that samples it and sets `auto_masked`. Further completions while the block is masked raise no request. `auto_masked` is 1 exactly when the count is non-zero.
- R4: A credit return that brings the count to zero clears `auto_masked` and raises no request.
- R5: A credit return that leaves a non-zero count keeps `auto_masked` set and raises `irq_req` for one cycle.
- R6: When a completion and a credit return arrive in the same cycle, the net change (+1 minus N) is applied first, and R4 or R5 is then chosen from the resulting count.
- R7: A credit return larger than the count (including any same-cycle completion) sets the count to zero and behaves as in R4. It also sets `over_return`, which stays at 1 until reset.
- R8: The count saturates at 2^CNT_W-1. A completion at that value leaves it unchanged.
- R9: `irq_vec` equals the VECTOR parameter in every cycle where `irq_req` is 1, and is 0 otherwise.
- R10: After reset the count is 0, `auto_masked` is 0, `irq_req` is 0, `irq_vec` is 0 and `over_return` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_pulse | input | 1 | One descriptor completed this cycle |
| credit_wr | input | 1 | Credit-return write strobe |
| credit_amt | input | CNT_W | Number of credits returned with `credit_wr` |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vec | output | VEC_W | Vector number during a request, else 0 |
| credits | output | CNT_W | Outstanding credit count |
| auto_masked | output | 1 | Auto-mask state (1 in HELD) |
| over_return | output | 1 | Sticky flag: more credits returned than were outstanding |

## Verification
A wrong count shows up on `credits` at the edge that samples the stimulus. It also shows up at the first later credit return, as a request that is missing or extra. A state machine stuck in HELD after a drain would stay silent on the next completion, which the bench checks one cycle later. A wrong decision order for a same-cycle completion and return shows up in the very next cycle as a request where the net count called for silence, or the other way round. Saturation is checked on a narrow-counter instance so that the top value can be reached in a few cycles.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;

    // OPEN: source unmasked, no credits owed; HELD: auto-masked, work owed
    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } imod_state_t;

endpackage

// File: rtl/imod_credit_calc.sv
module imod_credit_calc #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic             ret_valid_i,
    input  logic [CNT_W-1:0] ret_amt_i,
    output logic [CNT_W-1:0] credits_o,
    output logic             next_zero_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W:0]   WIDE_MAX = {1'b0, CNT_MAX};

    logic [CNT_W:0]   wide_sum;
    logic [CNT_W:0]   wide_amt;
    logic [CNT_W:0]   wide_diff;
    logic             under;
    logic [CNT_W-1:0] cnt_next;

    // net change first: +done, then -returned, clamp at both ends
    always_comb begin
        wide_sum  = {1'b0, credits_o} + {{CNT_W{1'b0}}, done_i};
        wide_amt  = ret_valid_i ? {1'b0, ret_amt_i} : '0;
        under     = (wide_amt > wide_sum);
        wide_diff = wide_sum - wide_amt;
        if (under)
            cnt_next = '0;
        else if (wide_diff > WIDE_MAX)
            cnt_next = CNT_MAX;
        else
            cnt_next = wide_diff[CNT_W-1:0];
        next_zero_o = (cnt_next == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credits_o <= '0;
            err_o     <= 1'b0;
        end else begin
            credits_o <= cnt_next;
            if (under)
                err_o <= 1'b1;
        end
    end

    // R1: a lone completion below the ceiling adds exactly one
    a_r1_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ret_valid_i && credits_o != CNT_MAX)
        |=> credits_o == $past(credits_o) + 1'b1);

    // R2: a lone return within range subtracts the amount
    a_r2_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && !done_i && ret_amt_i <= credits_o)
        |=> credits_o == $past(credits_o) - $past(ret_amt_i));

    // R7: error flag never clears outside reset
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R7: an over-return lands on zero
    a_r7_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && !done_i && ret_amt_i > credits_o)
        |=> (credits_o == '0 && err_o));

    // R8: ceiling holds under further completions
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (credits_o == CNT_MAX && !ret_valid_i) |=> credits_o == CNT_MAX);

endmodule

// File: rtl/imod_mask_fsm.sv
module imod_mask_fsm
    import irqmod_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int VECTOR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid_i,
    input  logic             next_zero_i,
    output logic             held_o,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam logic [VEC_W-1:0] VEC_TAG = VEC_W'(VECTOR);

    imod_state_t state_q;
    imod_state_t state_d;
    logic        fire;

    // next state and fire decision
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (!next_zero_i) begin      // arm-fire
                    state_d = ST_HELD;
                    fire    = 1'b1;
                end
            end
            ST_HELD: begin
                if (ret_valid_i) begin
                    if (next_zero_i)
                        state_d = ST_OPEN;   // drain-unmask
                    else
                        fire = 1'b1;         // partial-return refire
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OPEN;
        else
            state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            vec_o <= '0;
        end else begin
            irq_o <= fire;
            vec_o <= fire ? VEC_TAG : '0;
        end
    end

    assign held_o = (state_q == ST_HELD);

    // R3: a request is always followed by the masked state
    a_r3_fire_holds: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> held_o);

    // R4: draining return unmasks silently
    a_r4_silent_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && ret_valid_i && next_zero_i) |=> (!irq_o && !held_o));

    // R5: partial return refires and stays masked
    a_r5_refire: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && ret_valid_i && !next_zero_i) |=> (irq_o && held_o));

    // R9: vector tag only during a request
    a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o ? (vec_o == VEC_TAG) : (vec_o == '0));

endmodule

// File: rtl/irq_credit_moderator.sv
module irq_credit_moderator #(
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8,
    parameter int VECTOR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl_pulse,
    input  logic             credit_wr,
    input  logic [CNT_W-1:0] credit_amt,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [CNT_W-1:0] credits,
    output logic             auto_masked,
    output logic             over_return
);
    logic next_zero;

    imod_credit_calc #(
        .CNT_W (CNT_W)
    ) u_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (cmpl_pulse),
        .ret_valid_i (credit_wr),
        .ret_amt_i   (credit_amt),
        .credits_o   (credits),
        .next_zero_o (next_zero),
        .err_o       (over_return)
    );

    imod_mask_fsm #(
        .VEC_W  (VEC_W),
        .VECTOR (VECTOR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ret_valid_i (credit_wr),
        .next_zero_i (next_zero),
        .held_o      (auto_masked),
        .irq_o       (irq_req),
        .vec_o       (irq_vec)
    );

    // R3: mask state tracks whether credits are owed
    a_r3_mask_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        auto_masked == (credits != '0));

endmodule

// File: tb/test_irq_credit_moderator.sv
`timescale 1ns/1ps
module test_irq_credit_moderator;

    localparam int CNT_W = 32;
    localparam int VEC_W = 8;
    localparam int VEC_A = 9;
    localparam int SW    = 4;
    localparam int VEC_B = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             cmpl = 1'b0, cwr = 1'b0;
    logic [CNT_W-1:0] camt = '0;
    logic             irq, msk, err;
    logic [VEC_W-1:0] vec;
    logic [CNT_W-1:0] cred;

    logic             s_cmpl = 1'b0, s_cwr = 1'b0;
    logic [SW-1:0]    s_camt = '0;
    logic             s_irq, s_msk, s_err;
    logic [VEC_W-1:0] s_vec;
    logic [SW-1:0]    s_cred;

    int total = 0;
    int bad   = 0;

    irq_credit_moderator #(.CNT_W(CNT_W), .VEC_W(VEC_W), .VECTOR(VEC_A)) i_irq_credit_moderator (
        .clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl), .credit_wr(cwr), .credit_amt(camt),
        .irq_req(irq), .irq_vec(vec), .credits(cred), .auto_masked(msk), .over_return(err));

    irq_credit_moderator #(.CNT_W(SW), .VEC_W(VEC_W), .VECTOR(VEC_B)) i_small (
        .clk(clk), .rst_n(rst_n), .cmpl_pulse(s_cmpl), .credit_wr(s_cwr), .credit_amt(s_camt),
        .irq_req(s_irq), .irq_vec(s_vec), .credits(s_cred), .auto_masked(s_msk), .over_return(s_err));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at negedge, sample just after the next posedge
    task automatic apply(input logic d, input logic w, input logic [CNT_W-1:0] a);
        @(negedge clk);
        cmpl = d; cwr = w; camt = a;
        @(posedge clk);
        #1;
        cmpl = 1'b0; cwr = 1'b0; camt = '0;
    endtask

    task automatic apply_s(input logic d, input logic w, input logic [SW-1:0] a);
        @(negedge clk);
        s_cmpl = d; s_cwr = w; s_camt = a;
        @(posedge clk);
        #1;
        s_cmpl = 1'b0; s_cwr = 1'b0; s_camt = '0;
    endtask

    task automatic t_reset;
        check("R10 credits", cred, 0);
        check("R10 masked", msk, 0);
        check("R10 irq", irq, 0);
        check("R10 vec", vec, 0);
        check("R10 err", err, 0);
    endtask

    task automatic t_first_fire;
        apply(1, 0, 0);
        check("R3 first irq", irq, 1);
        check("R9 vec tag", vec, VEC_A);
        check("R1 count one", cred, 1);
        check("R3 masked", msk, 1);
        apply(1, 0, 0);
        check("R3 no irq while masked", irq, 0);
        apply(1, 0, 0);
        check("R1 count three", cred, 3);
        check("R3 still silent", irq, 0);
        check("R9 vec idle", vec, 0);
    endtask

    task automatic t_partial;
        apply(0, 1, 1);
        check("R2 count two", cred, 2);
        check("R5 refire", irq, 1);
        check("R5 stays masked", msk, 1);
        apply(0, 0, 0);
        check("R5 single pulse", irq, 0);
    endtask

    task automatic t_drain;
        apply(0, 1, 2);
        check("R4 count zero", cred, 0);
        check("R4 no irq", irq, 0);
        check("R4 unmasked", msk, 0);
        apply(1, 0, 0);
        check("R3 rearm fire", irq, 1);
    endtask

    task automatic t_same_cycle;
        // count 1: +1 -2 -> 0
        apply(1, 1, 2);
        check("R6 net zero", cred, 0);
        check("R6 net zero silent", irq, 0);
        check("R6 net zero unmask", msk, 0);
        apply(1, 0, 0);
        apply(1, 0, 0);
        check("R1 count two", cred, 2);
        // count 2: +1 -2 -> 1
        apply(1, 1, 2);
        check("R6 net one", cred, 1);
        check("R6 net one refire", irq, 1);
        check("R6 net one masked", msk, 1);
    endtask

    task automatic t_over;
        apply(0, 1, 5);
        check("R7 clamp", cred, 0);
        check("R7 err set", err, 1);
        check("R7 silent", irq, 0);
        check("R7 unmasked", msk, 0);
        apply(0, 0, 0);
        check("R7 err sticky", err, 1);
        apply(1, 0, 0);
        check("R7 fire after clamp", irq, 1);
        check("R7 err kept", err, 1);
        apply(1, 1, 3);
        check("R7 over with completion", cred, 0);
        check("R7 over with completion silent", irq, 0);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 17; i++) apply_s(1, 0, 0);
        check("R8 saturated", s_cred, 15);
        check("R8 no irq", s_irq, 0);
        apply_s(1, 0, 0);
        check("R8 held at max", s_cred, 15);
        apply_s(1, 1, 1);
        check("R8 net at max", s_cred, 15);
        check("R9 small vec", s_vec, VEC_B);
        apply_s(0, 1, 15);
        check("R4 small drain", s_cred, 0);
        check("R4 small unmask", s_msk, 0);
        check("R7 small no err", s_err, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_first_fire();
        t_partial();
        t_drain();
        t_same_cycle();
        t_over();
        t_saturate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule